// File: doc/BRIEF.md
# Dual-Channel Double-Data-Rate Output Formatter

This block takes two channels of 16-bit sample words, each with its own overflow flag, and presents them on a 34-line output bus. A new sample pair arrives once per sample period. Each pair passes through a fixed delay of six sample periods. It then leaves the block in one of two formats, chosen by a 2-bit mode input.

In full-rate format, each channel drives 17 lines (16 data bits and the overflow flag), and the word holds for the whole sample period. In double-data-rate format, each channel uses 8 lanes. Lane k carries bit 2k in the first half of the period and bit 2k+1 in the second half. The two overflow flags share one lane: channel 1's flag in the first half and channel 2's flag in the second. This halves the number of active lines.

A forwarded clock travels with the data. The block runs on a single internal clock at twice the sample rate. A phase bit, cleared by reset, marks the first half of each sample period, and samples are captured on the first-half edge. An output-off input forces every lane and the forwarded clock to zero, while the delay line keeps running. Mode and output-off changes take effect only at a sample boundary.

Top module: `ddr_fmt_top`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, all lanes and `clk_out` are 0.
- R2: Full-rate mode (mode 0 or 3) drives `lanes[15:0]` with channel 1 data, `lanes[16]` with channel 1 overflow, `lanes[32:17]` with channel 2 data and `lanes[33]` with channel 2 overflow. The values are held for both halves of the period.
- R3: Double-data-rate mode (mode 1 or 2) drives channel 1 pairs on `lanes[7:0]` and channel 2 pairs on `lanes[15:8]`. Lane k carries bit 2k in the first half and bit 2k+1 in the second half. `lanes[33:17]` are 0.
- R4: A sample captured on the first-half edge of sample period n appears on the lanes from the first-half edge of period n+6. Before six periods have passed since reset, the word shown is all zeros.
- R5: `clk_out` is 0 during the first half and 1 during the second half of every enabled period. Data therefore changes on its falling edge in every mode, and also on its rising edge in double-data-rate mode. It is never high in two consecutive internal cycles.
- R6: When output-off is taken at a sample boundary, all lanes and `clk_out` are 0 for that whole period.
- R7: In double-data-rate mode, `lanes[16]` carries channel 1 overflow in the first half and channel 2 overflow in the second half.
- R8: Modes 1 and 2 give identical lane contents. Mode 3 behaves as mode 0.
- R9: Mode and output-off are sampled only at the first-half edge. Changes during the second half have no effect until the next period.
- R10: The delay line advances while outputs are off. The first period after re-enable shows the sample captured six periods earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock at twice the sample rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| ch1_data | input | 16 | Channel 1 sample word |
| ch1_ovf | input | 1 | Channel 1 overflow flag |
| ch2_data | input | 16 | Channel 2 sample word |
| ch2_ovf | input | 1 | Channel 2 overflow flag |
| out_mode | input | 2 | 0 full-rate, 1 and 2 double-data-rate, 3 full-rate |
| out_off | input | 1 | Force lanes and forwarded clock to zero |
| lanes | output | 34 | Output lane bus |
| clk_out | output | 1 | Forwarded clock |

## Verification
The hardest case to reach from the ports is a control change that lands in the second half of a period, where it must not touch the word already on the lanes. It is equally hard to confirm that the delay line keeps advancing during an off stretch. The stimulus drives fresh random values of mode and output-off on every internal cycle, so both halves see changes. It also holds output-off for stretches that are shorter and longer than the six-period delay. A behavioural queue model predicts each half, including the zero words that drain out after reset.

// File: rtl/ddr_fmt_pkg.sv
package ddr_fmt_pkg;

    typedef enum logic [1:0] {
        OM_FULL     = 2'd0,
        OM_DDR_CMOS = 2'd1,
        OM_DDR_LVDS = 2'd2,
        OM_FULL_ALT = 2'd3
    } out_mode_e;

    // Both double-data-rate codes share one digital lane format.
    function automatic logic mode_is_ddr(input logic [1:0] m);
        return (out_mode_e'(m) == OM_DDR_CMOS) || (out_mode_e'(m) == OM_DDR_LVDS);
    endfunction

endpackage

// File: rtl/ddr_fmt_phase.sv
// Half-period marker: 0 on the first-half edge of each sample period.
module ddr_fmt_phase (
    input  logic clk,
    input  logic rst_n,
    output logic phase
);
    logic phase_d, phase_q;

    always_comb begin
        phase_d = ~phase_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) phase_q <= 1'b0;
        else        phase_q <= phase_d;
    end

    assign phase = phase_q;
endmodule

// File: rtl/ddr_fmt_delay.sv
// Fixed sample-period delay line, advanced once per sample period.
module ddr_fmt_delay #(
    parameter int W     = 34,
    parameter int DEPTH = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         adv,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] st_d [DEPTH];
    logic [W-1:0] st_q [DEPTH];

    generate
        for (genvar i = 0; i < DEPTH; i++) begin : g_stage
            if (i == 0) begin : g_head
                always_comb st_d[i] = adv ? din : st_q[i];
            end else begin : g_body
                always_comb st_d[i] = adv ? st_q[i-1] : st_q[i];
            end
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) st_q[i] <= '0;
                else        st_q[i] <= st_d[i];
            end
        end
    endgenerate

    assign dout = st_q[DEPTH-1];
endmodule

// File: rtl/ddr_fmt_lanes.sv
// Combinational lane mapper for one half of a sample period.
module ddr_fmt_lanes #(
    parameter int DW = 16
) (
    input  logic [DW:0]       word_a,   // {ovf, data} channel 1
    input  logic [DW:0]       word_b,   // {ovf, data} channel 2
    input  logic              ddr,
    input  logic              half,     // 0 first half, 1 second half
    input  logic              off,
    output logic [2*DW+1:0]   lanes
);
    localparam int LPC = DW / 2;
    localparam int NL  = 2 * (DW + 1);

    logic [NL-1:0] full_map;
    logic [NL-1:0] ddr_map;

    assign full_map = {word_b, word_a};

    generate
        for (genvar k = 0; k < LPC; k++) begin : g_pair
            assign ddr_map[k]       = half ? word_a[2*k+1] : word_a[2*k];
            assign ddr_map[LPC + k] = half ? word_b[2*k+1] : word_b[2*k];
        end
    endgenerate

    assign ddr_map[DW]        = half ? word_b[DW] : word_a[DW];
    assign ddr_map[NL-1:DW+1] = '0;

    always_comb begin
        if (off)      lanes = '0;
        else if (ddr) lanes = ddr_map;
        else          lanes = full_map;
    end
endmodule

// File: rtl/ddr_fmt_top.sv
module ddr_fmt_top
    import ddr_fmt_pkg::*;
#(
    parameter int DW  = 16,
    parameter int LAT = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [DW-1:0]       ch1_data,
    input  logic                ch1_ovf,
    input  logic [DW-1:0]       ch2_data,
    input  logic                ch2_ovf,
    input  logic [1:0]          out_mode,
    input  logic                out_off,
    output logic [2*DW+1:0]     lanes,
    output logic                clk_out
);
    localparam int WW = DW + 1;
    localparam int NL = 2 * WW;

    typedef struct packed {
        logic [NL-1:0] word;
        logic          ddr;
        logic          off;
        logic [NL-1:0] lanes;
        logic          clk;
    } st_t;

    st_t           s_d, s_q;
    logic          phase;
    logic [NL-1:0] dly_out;
    logic [NL-1:0] fmt_word;
    logic          fmt_ddr;
    logic          fmt_off;
    logic [NL-1:0] lanes_nxt;

    ddr_fmt_phase u_phase (
        .clk   (clk),
        .rst_n (rst_n),
        .phase (phase)
    );

    ddr_fmt_delay #(.W(NL), .DEPTH(LAT)) u_delay (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (~phase),
        .din   ({ch2_ovf, ch2_data, ch1_ovf, ch1_data}),
        .dout  (dly_out)
    );

    // Controls and word are taken at the first-half edge and reused for the second half.
    always_comb begin
        fmt_word = phase ? s_q.word : dly_out;
        fmt_ddr  = phase ? s_q.ddr  : mode_is_ddr(out_mode);
        fmt_off  = phase ? s_q.off  : out_off;
    end

    ddr_fmt_lanes #(.DW(DW)) u_lanes (
        .word_a (fmt_word[WW-1:0]),
        .word_b (fmt_word[NL-1:WW]),
        .ddr    (fmt_ddr),
        .half   (phase),
        .off    (fmt_off),
        .lanes  (lanes_nxt)
    );

    always_comb begin
        s_d       = s_q;
        s_d.word  = fmt_word;
        s_d.ddr   = fmt_ddr;
        s_d.off   = fmt_off;
        s_d.lanes = lanes_nxt;
        s_d.clk   = fmt_off ? 1'b0 : phase;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign lanes   = s_q.lanes;
    assign clk_out = s_q.clk;
endmodule

// File: rtl/ddr_fmt_chk.sv
module ddr_fmt_chk
    import ddr_fmt_pkg::*;
#(
    parameter int DW = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              phase,
    input logic [1:0]        out_mode,
    input logic              out_off,
    input logic [2*DW+1:0]   lanes,
    input logic              clk_out
);
    // R5: forwarded clock never stays high across two internal cycles
    a_r5_clk_single_high: assert property (@(posedge clk) disable iff (!rst_n)
        clk_out |=> !clk_out);

    // R6: off taken at a boundary idles both halves
    a_r6_off_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!phase && out_off) |=> (lanes == '0 && !clk_out) ##1 (lanes == '0 && !clk_out));

    // R3: upper lanes idle in double-data-rate periods
    a_r3_ddr_upper_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!phase && mode_is_ddr(out_mode)) |=> (lanes[2*DW+1:DW+1] == '0));

    // R2: full-rate word holds across both halves
    a_r2_full_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!phase && !mode_is_ddr(out_mode)) |=> ##1 $stable(lanes));
endmodule

bind ddr_fmt_top ddr_fmt_chk #(.DW(DW)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .phase    (phase),
    .out_mode (out_mode),
    .out_off  (out_off),
    .lanes    (lanes),
    .clk_out  (clk_out)
);

// File: tb/ddr_fmt_top_tb_top.sv
module ddr_fmt_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] ch1_data = '0, ch2_data = '0;
    logic        ch1_ovf = 1'b0, ch2_ovf = 1'b0;
    logic [1:0]  out_mode = 2'd0;
    logic        out_off = 1'b0;
    logic [33:0] lanes;
    logic        clk_out;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #2.5 clk = ~clk;

    ddr_fmt_top dut_i (
        .clk(clk), .rst_n(rst_n),
        .ch1_data(ch1_data), .ch1_ovf(ch1_ovf),
        .ch2_data(ch2_data), .ch2_ovf(ch2_ovf),
        .out_mode(out_mode), .out_off(out_off),
        .lanes(lanes), .clk_out(clk_out)
    );

    // reference state
    logic [33:0] hist[$];
    logic [33:0] cur_w;
    bit          cur_ddr, cur_off;
    int          ecount;

    function automatic logic [33:0] expect_lanes(logic [33:0] w, bit ddr, bit off, bit half);
        logic [33:0] r = '0;
        if (off) return r;
        if (!ddr) return w;
        for (int k = 0; k < 8; k++) begin
            r[k]     = half ? w[2*k+1]    : w[2*k];
            r[8 + k] = half ? w[17+2*k+1] : w[17+2*k];
        end
        r[16] = half ? w[33] : w[16];
        return r;
    endfunction

    task automatic check(string tag, logic [33:0] got, logic [33:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h at edge %0d", tag, got, exp, ecount);
        end
    endtask

    // Drive one internal cycle, update the model, and check after the edge.
    task automatic step(logic [15:0] d1, bit o1, logic [15:0] d2, bit o2,
                        logic [1:0] m, bit off, string ctx);
        bit half;
        string tag;
        logic [33:0] el;
        ch1_data = d1; ch1_ovf = o1; ch2_data = d2; ch2_ovf = o2;
        out_mode = m;  out_off = off;
        half = ecount[0];
        if (!half) begin
            hist.push_back({o2, d2, o1, d1});
            cur_w   = hist.pop_front();
            cur_ddr = (m == 2'd1) || (m == 2'd2);
            cur_off = off;
        end
        el = expect_lanes(cur_w, cur_ddr, cur_off, half);
        if (ctx != "")     tag = ctx;
        else if (cur_off)  tag = "R6";
        else if (cur_ddr)  tag = "R3,R7";
        else               tag = "R2";
        @(posedge clk);
        @(negedge clk);
        check(tag, lanes, el);
        check("R5", {33'd0, clk_out}, {33'd0, (!cur_off && half)});
        ecount++;
    endtask

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        ecount = 0;
        repeat (4) @(negedge clk);
        // R1: reset state
        check("R1", lanes, '0);
        check("R1", {33'd0, clk_out}, 34'd0);
        for (int i = 0; i < 6; i++) hist.push_back('0);
        rst_n = 1'b1;

        // R1/R4: zero word drains out of the delay line first
        for (int i = 0; i < 12; i++)
            step(16'(i * 16'h1111 + 1), 1'b1, 16'(16'hF00F ^ i), 1'b1, 2'd0, 1'b0, "R1,R4");

        // R4: marker sample in full rate on an otherwise quiet input
        for (int i = 0; i < 20; i++)
            step(i == 0 ? 16'hA5C3 : 16'h0, i == 0, i == 0 ? 16'h3C5A : 16'h0, 1'b0,
                 2'd0, 1'b0, "R4");

        // R2: full-rate random
        for (int i = 0; i < 200; i++)
            step(16'($urandom), 1'($urandom), 16'($urandom), 1'($urandom), 2'd0, 1'b0, "");

        // R3, R7: DDR CMOS random, including walking patterns
        for (int i = 0; i < 200; i++)
            step(i < 32 ? 16'(1 << (i/2)) : 16'($urandom), 1'($urandom),
                 i < 32 ? ~16'(1 << (i/2)) : 16'($urandom), 1'($urandom), 2'd1, 1'b0, "");

        // R8: DDR LVDS code and reserved code 3
        for (int i = 0; i < 100; i++)
            step(16'($urandom), 1'($urandom), 16'($urandom), 1'($urandom), 2'd2, 1'b0, "R8");
        for (int i = 0; i < 100; i++)
            step(16'($urandom), 1'($urandom), 16'($urandom), 1'($urandom), 2'd3, 1'b0, "R8");

        // R9: mode and off change every internal cycle, second-half values ignored
        for (int i = 0; i < 400; i++)
            step(16'($urandom), 1'($urandom), 16'($urandom), 1'($urandom),
                 2'($urandom), 1'($urandom_range(0, 3) == 0), "R9");

        // R6, R10: off stretches shorter and longer than the delay, then re-enable
        for (int r = 0; r < 6; r++) begin
            for (int i = 0; i < 2 * (r * 3 + 2); i++)
                step(16'($urandom), 1'($urandom), 16'($urandom), 1'($urandom),
                     2'(r % 3), 1'b1, "R6");
            for (int i = 0; i < 14; i++)
                step(16'($urandom), 1'($urandom), 16'($urandom), 1'($urandom),
                     2'(r % 3), 1'b0, "R10");
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule